// File: doc/BRIEF.md
# SAR Converter Digital Sequencer

This block is the digital half of a 12-bit successive-approximation converter. It controls the sample/hold switch and drives a trial code into an external capacitor DAC. It reads back a single comparator bit and builds the result one bit at a time. Each decided bit goes out on a serial data pin in the same clock period in which it is resolved, so the result carries no pipeline delay. The analog comparator, DAC and reference are modelled outside the block.

A single active-low convert/control input runs the whole interface. Its level at particular clock counts selects one of four endings for a conversion:
- a normal finish with the data pin released;
- power-down when the input is held LOW throughout;
- a second, least-significant-first pass over the result bits;
- an immediate abort that cuts the conversion short.

The hold switch closes as soon as the convert input falls. All other outputs are registered on the rising clock edge. The numbering used below counts as clock 1 the period that begins at the first rising edge that samples convert LOW while the block is sampling. Clock n is the period that starts n-1 edges later.

Top module: `sar_sequencer`

## Requirements
- R1: `hold` is HIGH whenever `conv_ctl` is LOW, with no clock edge needed. It stays HIGH from clock 1 through clock 13 of a conversion. While sampling, with `conv_ctl` HIGH, it is LOW.
- R2: In clock 1, `sdata_oe` is 1, `sdata` is 0 and `trial_code` is 0x800, which is only the most significant bit set.
- R3: At each decision edge, the bit under trial stays 1 if `cmp_ge` is 1 (input at or above the DAC level) and becomes 0 otherwise. The next lower bit is then set to 1. From clock 13 on, `trial_code` equals the straight-binary input code, the largest code the comparator accepts (one LSB is full scale divided by 4096).
- R4: In clocks 2 to 13, `sdata` carries result bits 11 down to 0, most significant first, with `sdata_oe` at 1.
- R5: If `conv_ctl` is HIGH at the edge that ends clock 13, the block is idle from the next clock. In idle, `sdata_oe` is 0, `pdown` is 0, and further clocks leave `trial_code` unchanged while `conv_ctl` stays HIGH.
- R6: If `conv_ctl` stays LOW from the start through the edge that ends clock 12, `pdown` is 1 in clock 13. From clock 14 `sdata_oe` is 0, and `pdown` stays 1 while `conv_ctl` remains LOW.
- R7: A HIGH on `conv_ctl`, sampled at a clock edge while `pdown` is 1, gives `pdown` = 0 and `sdata_oe` = 0 in the following clock. `hold` is 0 as soon as `conv_ctl` is HIGH.
- R8: Least-significant-first mode is entered when `conv_ctl` is sampled HIGH at an edge ending one of clocks 1 to 12 and sampled LOW at the edge ending clock 13. Clocks 14 to 24 then carry result bits 1 up to 11, and `pdown` is 1 from clock 14. From clock 25, `sdata` is driven 0 with `sdata_oe` = 1 until `conv_ctl` goes HIGH.
- R9: If `conv_ctl` is sampled HIGH at one edge and then LOW at a later edge ending a clock no later than clock 12, the conversion stops. In the next clock `sdata_oe` is 0 and `pdown` is 1.
- R10: While `rst_n` is LOW, `sdata_oe`, `sdata` and `pdown` are 0 and `trial_code` is 0, even in the middle of a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_ctl | input | 1 | Active-low convert/control level; a LOW starts a conversion |
| cmp_ge | input | 1 | Comparator: 1 when the held input is at or above the DAC level |
| trial_code | output | NBITS | Trial code for the capacitor DAC; holds the result after the last decision |
| hold | output | 1 | 1 = hold capacitor isolated, 0 = tracking the input |
| pdown | output | 1 | Power-down indication |
| sdata | output | 1 | Serial result bit |
| sdata_oe | output | 1 | Output enable for the serial pin; 0 = high impedance |

## Verification
`hold` is combinational on `conv_ctl`. The bench therefore checks it 1 ns after driving `conv_ctl` LOW, before any clock edge. Every other result is registered, so a level applied to `conv_ctl` or `cmp_ge` becomes visible exactly one rising edge later. Inputs change only on falling edges, and outputs are sampled on the following falling edge, one edge after the stimulus, which is the cycle the output is due. The clock-13 decisions are taken at the edge ending clock 13, so the bench expects the idle, power-down or second-pass outputs in clock 14. It drives `cmp_ge` from a behavioural comparison of its own input value against `trial_code`, so each expected serial bit follows directly from that value.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [2:0] {
      ST_SAMPLE,
      ST_CONV,
      ST_LSBREP,
      ST_TAIL,
      ST_PDOWN
   } seq_state_e;

   function automatic int cnt_width(input int nbits);
      return $clog2(2 * nbits + 1) + 1;
   endfunction

endpackage

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
   parameter int NBITS = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             decide,
   input  logic             cmp_ge,
   output logic [NBITS-1:0] code
);
   localparam logic [NBITS-1:0] TOP_ONLY = {1'b1, {(NBITS-1){1'b0}}};

   logic [NBITS-1:0] code_q, code_d, cur_q;
   logic [NBITS:0]   cur_ext;

   assign cur_ext = {1'b0, cur_q};

   generate
      for (genvar g = 0; g < NBITS; g++) begin : g_bit
         assign code_d[g] = start  ? TOP_ONLY[g] :
                            decide ? (cur_q[g]       ? cmp_ge :
                                      cur_ext[g + 1] ? 1'b1   : code_q[g]) :
                                     code_q[g];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         cur_q  <= '0;
      end else begin
         code_q <= code_d;
         if (start)
            cur_q <= TOP_ONLY;
         else if (decide)
            cur_q <= cur_q >> 1;
      end
   end

   assign code = code_q;
endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
   import sar_seq_pkg::*;
#(
   parameter int NBITS = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_ctl,
   input  logic             cmp_ge,
   input  logic [NBITS-1:0] code,
   output logic             start,
   output logic             decide,
   output logic             busy,
   output logic             sdata,
   output logic             sdata_oe,
   output logic             pdown
);
   localparam int            CW       = cnt_width(NBITS);
   localparam logic [CW-1:0] LAST_DEC = CW'(NBITS);
   localparam logic [CW-1:0] REP_END  = CW'(2 * NBITS);
   localparam logic [CW-1:0] ONE      = CW'(1);

   seq_state_e       st_q, st_n;
   logic [CW-1:0]    cnt_q, cnt_n;
   logic             hi_q, hi_n, pd_q, pd_n, sd_q, sd_n, oe_q, oe_n;
   logic [NBITS-1:0] rep_vec;
   logic             rep_bit;

   assign rep_vec = code >> (cnt_q - LAST_DEC);
   assign rep_bit = rep_vec[0];

   always_comb begin
      st_n   = st_q;
      cnt_n  = cnt_q;
      hi_n   = hi_q;
      pd_n   = pd_q;
      sd_n   = sd_q;
      oe_n   = oe_q;
      start  = 1'b0;
      decide = 1'b0;
      unique case (st_q)
         ST_SAMPLE: begin
            if (!conv_ctl) begin
               st_n  = ST_CONV;
               cnt_n = ONE;
               hi_n  = 1'b0;
               sd_n  = 1'b0;
               oe_n  = 1'b1;
               start = 1'b1;
            end
         end
         ST_CONV: begin
            if (cnt_q <= LAST_DEC) begin
               if (hi_q && !conv_ctl) begin
                  st_n = ST_PDOWN;
                  pd_n = 1'b1;
                  oe_n = 1'b0;
                  sd_n = 1'b0;
               end else begin
                  decide = 1'b1;
                  sd_n   = cmp_ge;
                  cnt_n  = cnt_q + ONE;
                  hi_n   = hi_q | conv_ctl;
                  if (cnt_q == LAST_DEC && !conv_ctl && !hi_q)
                     pd_n = 1'b1;
               end
            end else if (conv_ctl) begin
               st_n = ST_SAMPLE;
               pd_n = 1'b0;
               oe_n = 1'b0;
               sd_n = 1'b0;
            end else if (hi_q) begin
               st_n  = ST_LSBREP;
               pd_n  = 1'b1;
               cnt_n = cnt_q + ONE;
               sd_n  = rep_bit;
            end else begin
               st_n = ST_PDOWN;
               pd_n = 1'b1;
               oe_n = 1'b0;
               sd_n = 1'b0;
            end
         end
         ST_LSBREP: begin
            if (conv_ctl) begin
               st_n = ST_SAMPLE;
               pd_n = 1'b0;
               oe_n = 1'b0;
               sd_n = 1'b0;
            end else if (cnt_q == REP_END) begin
               st_n = ST_TAIL;
               sd_n = 1'b0;
            end else begin
               cnt_n = cnt_q + ONE;
               sd_n  = rep_bit;
            end
         end
         ST_TAIL, ST_PDOWN: begin
            if (conv_ctl) begin
               st_n = ST_SAMPLE;
               pd_n = 1'b0;
               oe_n = 1'b0;
               sd_n = 1'b0;
            end
         end
         default: st_n = ST_SAMPLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_SAMPLE;
         cnt_q <= '0;
         hi_q  <= 1'b0;
         pd_q  <= 1'b0;
         sd_q  <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         st_q  <= st_n;
         cnt_q <= cnt_n;
         hi_q  <= hi_n;
         pd_q  <= pd_n;
         sd_q  <= sd_n;
         oe_q  <= oe_n;
      end
   end

   assign busy     = (st_q == ST_CONV) || (st_q == ST_LSBREP);
   assign sdata    = sd_q;
   assign sdata_oe = oe_q;
   assign pdown    = pd_q;
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
   parameter int NBITS = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_ctl,
   input  logic             cmp_ge,
   output logic [NBITS-1:0] trial_code,
   output logic             hold,
   output logic             pdown,
   output logic             sdata,
   output logic             sdata_oe
);
   generate
      if (NBITS < 4 || NBITS > 16) begin : g_bad_width
         $error("sar_sequencer: NBITS must lie between 4 and 16");
      end
   endgenerate

   logic start, decide, busy;

   sar_trial_reg #(.NBITS(NBITS)) u_trial (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .decide (decide),
      .cmp_ge (cmp_ge),
      .code   (trial_code)
   );

   sar_seq_fsm #(.NBITS(NBITS)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .conv_ctl (conv_ctl),
      .cmp_ge   (cmp_ge),
      .code     (trial_code),
      .start    (start),
      .decide   (decide),
      .busy     (busy),
      .sdata    (sdata),
      .sdata_oe (sdata_oe),
      .pdown    (pdown)
   );

   // track/hold switch: closes on the convert level itself, not on a clock
   assign hold = busy | ~conv_ctl;
endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk #(
   parameter int NBITS = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             conv_ctl,
   input logic [NBITS-1:0] trial_code,
   input logic             hold,
   input logic             pdown,
   input logic             sdata,
   input logic             sdata_oe
);
   localparam logic [NBITS-1:0] TOP_ONLY = {1'b1, {(NBITS-1){1'b0}}};

   assert_hold_on_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_ctl |-> hold);

   assert_first_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdata_oe) |-> (!sdata && trial_code == TOP_ONLY));

   assert_idle_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sdata_oe && !pdown && conv_ctl) |=> $stable(trial_code));

   assert_pdown_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pdown && !conv_ctl) |=> pdown);

   assert_pdown_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pdown && conv_ctl) |=> (!pdown && !sdata_oe));
endmodule

bind sar_sequencer sar_sequencer_chk #(.NBITS(NBITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .conv_ctl   (conv_ctl),
   .trial_code (trial_code),
   .hold       (hold),
   .pdown      (pdown),
   .sdata      (sdata),
   .sdata_oe   (sdata_oe)
);

// File: tb/test_sar_sequencer.sv
module test_sar_sequencer;
   localparam int NB = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          conv_ctl = 1'b1;
   logic [NB-1:0] vin = '0;
   logic          cmp_ge;
   logic [NB-1:0] trial_code;
   logic          hold, pdown, sdata, sdata_oe;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   // behavioural comparator: held input against the DAC trial level
   assign cmp_ge = (vin >= trial_code);

   sar_sequencer #(.NBITS(NB)) i_sar_sequencer (
      .clk        (clk),
      .rst_n      (rst_n),
      .conv_ctl   (conv_ctl),
      .cmp_ge     (cmp_ge),
      .trial_code (trial_code),
      .hold       (hold),
      .pdown      (pdown),
      .sdata      (sdata),
      .sdata_oe   (sdata_oe)
   );

   // {abort clock[3:0], mode[1:0], input code[11:0]}; mode 0 normal, 1 power-down, 2 lsb-first, 3 abort
   localparam logic [17:0] VEC [10] = '{
      {4'd0,  2'd0, 12'hA5C},
      {4'd0,  2'd0, 12'h000},
      {4'd0,  2'd0, 12'hFFF},
      {4'd0,  2'd1, 12'h3C7},
      {4'd0,  2'd2, 12'h9B1},
      {4'd0,  2'd2, 12'h001},
      {4'd2,  2'd3, 12'h7FF},
      {4'd12, 2'd3, 12'h800},
      {4'd7,  2'd3, 12'h555},
      {4'd0,  2'd1, 12'hFFE}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run_conv(input logic [NB-1:0] v, input logic [1:0] mode, input int abort_clk);
      vin      = v;
      conv_ctl = 1'b0;
      #1;
      chk("R1 hold closes before any edge", 32'(hold), 32'd1);
      chk("R1 pin still released before clock 1", 32'(sdata_oe), 32'd0);
      for (int k = 1; k <= 13; k++) begin
         step();
         if (k == 1) begin
            chk("R2 enable in clock 1", 32'(sdata_oe), 32'd1);
            chk("R2 low lead bit", 32'(sdata), 32'd0);
            chk("R2 msb-only trial", 32'(trial_code), 32'h800);
         end else begin
            chk("R4 serial bit msb first", 32'(sdata), 32'(v[13-k]));
            chk("R4 enable held", 32'(sdata_oe), 32'd1);
         end
         chk("R1 hold through conversion", 32'(hold), 32'd1);
         if (mode == 2'd3 && k == abort_clk) begin
            conv_ctl = 1'b0;
            step();
            chk("R9 abort releases pin", 32'(sdata_oe), 32'd0);
            chk("R9 abort powers down", 32'(pdown), 32'd1);
            conv_ctl = 1'b1;
            step();
            chk("R7 exit after abort", 32'(pdown), 32'd0);
            chk("R7 hold opens", 32'(hold), 32'd0);
            return;
         end
         if (k == 13) begin
            chk("R3 final code straight binary", 32'(trial_code), 32'(v));
            chk("R6 pdown in clock 13", 32'(pdown), (mode == 2'd1) ? 32'd1 : 32'd0);
         end
         if (k == 1 && mode != 2'd1) conv_ctl = 1'b1;
         if (k == 13 && mode == 2'd2) conv_ctl = 1'b0;
      end
      step();
      case (mode)
         2'd0: begin
            chk("R5 idle pin released", 32'(sdata_oe), 32'd0);
            chk("R5 idle powered", 32'(pdown), 32'd0);
            chk("R1 sampling hold low", 32'(hold), 32'd0);
            for (int j = 0; j < 3; j++) begin
               step();
               chk("R5 extra clocks ignored", 32'(trial_code), 32'(v));
               chk("R5 pin stays released", 32'(sdata_oe), 32'd0);
            end
         end
         2'd1: begin
            chk("R6 pin released after clock 13", 32'(sdata_oe), 32'd0);
            chk("R6 still powered down", 32'(pdown), 32'd1);
            for (int j = 0; j < 2; j++) begin
               step();
               chk("R6 power-down persists", 32'(pdown), 32'd1);
            end
            conv_ctl = 1'b1;
            #1;
            chk("R7 hold opens on rise", 32'(hold), 32'd0);
            @(negedge clk);
            step();
            chk("R7 pdown cleared", 32'(pdown), 32'd0);
            chk("R7 pin released", 32'(sdata_oe), 32'd0);
         end
         default: begin
            for (int j = 1; j <= 11; j++) begin
               chk("R8 lsb-first bit", 32'(sdata), 32'(v[j]));
               chk("R8 pdown during repeat", 32'(pdown), 32'd1);
               step();
            end
            for (int j = 0; j < 2; j++) begin
               chk("R8 tail driven low", 32'(sdata), 32'd0);
               chk("R8 tail enabled", 32'(sdata_oe), 32'd1);
               step();
            end
            conv_ctl = 1'b1;
            step();
            chk("R7 exit after repeat", 32'(pdown), 32'd0);
            chk("R7 pin released after repeat", 32'(sdata_oe), 32'd0);
            chk("R7 hold open after repeat", 32'(hold), 32'd0);
         end
      endcase
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset enable", 32'(sdata_oe), 32'd0);
      chk("R10 reset pdown", 32'(pdown), 32'd0);
      chk("R10 reset code", 32'(trial_code), 32'd0);
      chk("R1 reset hold follows convert", 32'(hold), 32'd0);
      rst_n = 1'b1;
      step();

      for (int i = 0; i < 10; i++) begin
         run_conv(VEC[i][11:0], VEC[i][13:12], int'(VEC[i][17:14]));
         step();
      end

      // reset in the middle of a conversion
      vin      = 12'h6A3;
      conv_ctl = 1'b0;
      repeat (4) step();
      rst_n = 1'b0;
      #1;
      chk("R10 mid-conversion enable", 32'(sdata_oe), 32'd0);
      chk("R10 mid-conversion code", 32'(trial_code), 32'd0);
      chk("R10 mid-conversion sdata", 32'(sdata), 32'd0);
      conv_ctl = 1'b1;
      @(negedge clk);
      rst_n = 1'b1;
      step();

      // back-to-back conversion after reset
      run_conv(12'h6A3, 2'd0, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule